// File: doc/BRIEF.md
# Inband Loopback Code Generator

This block sits in the transmit path of a 193-bit T1/J1 line and can replace the outgoing serial stream with a repeating loopback code. The code is 5 to 8 bits long and its content is taken from an 8-bit pattern word. Each clock is one bit time. A one-cycle frame sync pulse marks the cycle that carries the framing bit.

In framed operation, the framing bit slot keeps whatever the upstream frame generator put there, such as alignment, data link and CRC-6 content. The 192 payload bits carry the code. In unframed operation, all 193 bits carry the code.

The code phase only moves on bits that are replaced. The pattern therefore runs on without a break across framing bits and frame edges. Settings are taken in only at a frame sync. A change of enable or mode at that point sends the code again from its first bit.

Top module: `loopcode_gen`

## Requirements
- R1: While reset is held and in the first cycle after it, `ser_out` is 0. After reset the generator is disabled and passes the input through.
- R2: The output is registered. The bit shown on `ser_out` after a rising edge belongs to the input cycle sampled at that edge.
- R3: When the active enable is 0, `ser_out` equals `ser_in` delayed by one cycle.
- R4: The length codes `len_sel` 0, 1, 2 and 3 select 5, 6, 7 and 8 code bits. The code is the top bits of `code_pat`, starting at bit 7, sent MSB first. After the last bit it repeats from bit 7.
- R5: When enabled in framed mode (`unframed`=0), the bit in the frame sync cycle passes through unchanged. The other 192 bits of the frame carry the code.
- R6: When enabled in unframed mode (`unframed`=1), every bit, including the frame sync cycle, carries the code.
- R7: The code phase does not advance on a bit that is passed through. In framed mode, the payload bit after the framing bit continues the pattern where the previous frame stopped.
- R8: `code_en` and `unframed` are taken in only in a frame sync cycle, and they already apply to that cycle. If either one differs from the value in use, the code starts again at bit 7.
- R9: `len_sel` and `code_pat` are also taken in only in a frame sync cycle. If the phase lies past the end of a new, shorter length, the code continues from bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one bit per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_in | input | 1 | Serial bit from the frame generator |
| frame_sync | input | 1 | High in the framing-bit cycle of each 193-bit frame |
| code_en | input | 1 | Request to send the loopback code |
| unframed | input | 1 | 1: replace all bits, 0: replace payload only |
| len_sel | input | 2 | Code length select (5 + value bits) |
| code_pat | input | 8 | Code content, MSB first |
| ser_out | output | 1 | Serial bit after substitution |

## Verification
Every output bit is due exactly one clock after the input cycle it belongs to. Settings offered in a frame sync cycle already govern that same cycle's output, which appears one edge later. Settings offered mid-frame must have no effect until the next sync.

The bench drives inputs on the falling edge and runs its behavioural model in that same step. It compares `ser_out` at the following falling edge, so every comparison falls exactly one register stage after its stimulus. Enable, mode, length and pattern changes are deliberately applied mid-frame, to show that the output ignores them until the sync cycle.

// File: rtl/lcg_pkg.sv
package lcg_pkg;
  localparam int CODE_W  = 8;
  localparam int LSEL_W  = 2;
  localparam int PH_W    = $clog2(CODE_W);
  localparam int MIN_LEN = CODE_W - (1 << LSEL_W) + 1;

  typedef struct packed {
    logic              en;
    logic              uf;
    logic [LSEL_W-1:0] lsel;
    logic [CODE_W-1:0] pat;
  } cfg_t;

  // last phase index of the selected code length (R4)
  function automatic logic [PH_W-1:0] last_phase(input logic [LSEL_W-1:0] sel);
    return PH_W'(MIN_LEN - 1) + PH_W'(sel);
  endfunction

  // phase after a replaced bit, wrapping to the first code bit
  function automatic logic [PH_W-1:0] phase_step(input logic [PH_W-1:0] cur,
                                                 input logic [PH_W-1:0] last);
    return (cur >= last) ? '0 : cur + 1'b1;
  endfunction
endpackage

// File: rtl/lcg_cfg_latch.sv
module lcg_cfg_latch
  import lcg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic frame_sync,
  input  cfg_t cfg_in,
  output cfg_t cfg_eff,
  output logic restart
);
  cfg_t cfg_q;

  // new settings govern the sync cycle itself (R8, R9)
  assign cfg_eff = frame_sync ? cfg_in : cfg_q;
  assign restart = frame_sync && ((cfg_in.en != cfg_q.en) || (cfg_in.uf != cfg_q.uf));

  always_ff @(posedge clk) begin
    if (!rst_n)          cfg_q <= '0;
    else if (frame_sync) cfg_q <= cfg_in;
  end
endmodule

// File: rtl/lcg_phase.sv
module lcg_phase
  import lcg_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            restart,
  input  logic            replace,
  input  logic [PH_W-1:0] last,
  output logic [PH_W-1:0] cur_phase
);
  logic [PH_W-1:0] ph_q;

  // restart on mode change, wrap when a shorter length arrives (R8, R9)
  assign cur_phase = (restart || (ph_q > last)) ? '0 : ph_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       ph_q <= '0;
    else if (replace) ph_q <= phase_step(cur_phase, last);
    else              ph_q <= cur_phase;   // R7: hold on passed bits
  end
endmodule

// File: rtl/lcg_out_stage.sv
module lcg_out_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_in,
  input  logic replace,
  input  logic code_bit,
  output logic ser_out
);
  always_ff @(posedge clk) begin
    if (!rst_n) ser_out <= 1'b0;
    else        ser_out <= replace ? code_bit : ser_in;
  end
endmodule

// File: rtl/loopcode_gen.sv
module loopcode_gen
  import lcg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_in,
  input  logic              frame_sync,
  input  logic              code_en,
  input  logic              unframed,
  input  logic [LSEL_W-1:0] len_sel,
  input  logic [CODE_W-1:0] code_pat,
  output logic              ser_out
);
  cfg_t            cfg_in;
  cfg_t            cfg_eff;
  logic            restart;
  logic            replace;
  logic            code_bit;
  logic [PH_W-1:0] last;
  logic [PH_W-1:0] cur_phase;

  assign cfg_in = '{en: code_en, uf: unframed, lsel: len_sel, pat: code_pat};

  lcg_cfg_latch u_cfg (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync),
    .cfg_in(cfg_in), .cfg_eff(cfg_eff), .restart(restart)
  );

  assign last = last_phase(cfg_eff.lsel);
  // R5/R6: framing slot is kept only in framed mode
  assign replace  = cfg_eff.en && (cfg_eff.uf || !frame_sync);
  assign code_bit = cfg_eff.pat[PH_W'(CODE_W-1) - cur_phase];

  lcg_phase u_phase (
    .clk(clk), .rst_n(rst_n), .restart(restart), .replace(replace),
    .last(last), .cur_phase(cur_phase)
  );

  lcg_out_stage u_out (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .replace(replace),
    .code_bit(code_bit), .ser_out(ser_out)
  );
endmodule

// File: rtl/lcg_checker.sv
module lcg_checker
  import lcg_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            ser_in,
  input logic            frame_sync,
  input logic            ser_out,
  input logic            replace_w,
  input logic            restart_w,
  input logic            eff_en_w,
  input logic            eff_uf_w,
  input logic            code_bit_w,
  input logic [PH_W-1:0] cur_phase_w,
  input logic [PH_W-1:0] last_w
);
  a_r2_code_out: assert property (@(posedge clk) disable iff (!rst_n)
    replace_w |=> ser_out == $past(code_bit_w));

  a_r3_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    !replace_w |=> ser_out == $past(ser_in));

  a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (replace_w && cur_phase_w == last_w) |=> cur_phase_w == '0);

  a_r5_fbit_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_sync && eff_en_w && !eff_uf_w) |=> ser_out == $past(ser_in));

  a_r6_unframed_all: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_en_w && eff_uf_w) |-> replace_w);

  a_r7_hold_fbit: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_sync && eff_en_w && !eff_uf_w && !restart_w) |=> cur_phase_w == $past(cur_phase_w));

  a_r8_restart_at_sync: assert property (@(posedge clk) disable iff (!rst_n)
    restart_w |-> frame_sync);
endmodule

bind loopcode_gen lcg_checker u_chk (
  .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .frame_sync(frame_sync),
  .ser_out(ser_out), .replace_w(replace), .restart_w(restart),
  .eff_en_w(cfg_eff.en), .eff_uf_w(cfg_eff.uf), .code_bit_w(code_bit),
  .cur_phase_w(cur_phase), .last_w(last)
);

// File: tb/loopcode_gen_tb.sv
`timescale 1ns/1ps
module loopcode_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ser_in = 1'b0;
  logic       frame_sync = 1'b0;
  logic       code_en = 1'b0;
  logic       unframed = 1'b0;
  logic [1:0] len_sel = 2'd0;
  logic [7:0] code_pat = 8'h00;
  logic       ser_out;

  int checks = 0;
  int errors = 0;

  // behavioural reference state
  int   pos = 0;
  bit   m_en = 0, m_uf = 0;
  int   m_len = 5;
  bit [7:0] m_pat = 0;
  int   m_ph = 0;
  bit   have_exp = 0;
  bit   exp_bit;
  string exp_tag;

  always #4 clk = ~clk;

  loopcode_gen u_dut (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .frame_sync(frame_sync),
    .code_en(code_en), .unframed(unframed), .len_sel(len_sel),
    .code_pat(code_pat), .ser_out(ser_out)
  );

  task automatic check(input bit act, input bit exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: ser_out=%0b expected=%0b at bit %0d", tag, act, exp, pos);
    end
  endtask

  task automatic step();
    bit s, sy, rep, restart, lenchg;
    @(negedge clk);
    if (have_exp) check(ser_out, exp_bit, exp_tag);
    s  = 1'($urandom);
    sy = (pos == 0);
    ser_in = s;
    frame_sync = sy;
    restart = 0;
    lenchg = 0;
    if (sy) begin
      restart = (code_en != m_en) || (unframed != m_uf);
      lenchg  = (m_len != 5 + int'(len_sel));
      m_en = code_en; m_uf = unframed;
      m_len = 5 + int'(len_sel); m_pat = code_pat;
      if (restart) m_ph = 0;
    end
    if (m_ph >= m_len) m_ph = 0;
    rep = m_en && (m_uf || !sy);
    exp_bit = rep ? m_pat[7 - m_ph] : s;
    if (!m_en)                  exp_tag = "R2 R3 disabled passthrough";
    else if (restart && rep)    exp_tag = "R8 restart at sync";
    else if (sy && lenchg)      exp_tag = "R9 new length at sync";
    else if (sy && !m_uf)       exp_tag = "R5 framing bit kept";
    else if (pos == 1 && !m_uf) exp_tag = "R7 phase continues after F-bit";
    else if (m_uf)              exp_tag = "R6 unframed replace";
    else                        exp_tag = "R4 code content";
    if (rep) begin
      m_ph++;
      if (m_ph >= m_len) m_ph = 0;
    end
    have_exp = 1;
    pos = (pos + 1) % 193;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(ser_out, 1'b0, "R1 reset value");
    rst_n = 1'b1;
    @(negedge clk);
    check(ser_out, 1'b0, "R1 after reset");
    run(2 * 193);
    run(70);
    code_en = 1; unframed = 0; len_sel = 2'd3; code_pat = 8'hA5;   // R8 mid-frame
    run(123 + 3 * 193);
    run(50);
    len_sel = 2'd0; code_pat = 8'hB8;                               // R9 mid-frame
    run(143 + 2 * 193);
    run(90);
    unframed = 1; len_sel = 2'd1; code_pat = 8'h6C;                 // R6, R8
    run(103 + 2 * 193);
    len_sel = 2'd2; code_pat = 8'h3A;                               // R4 length 7
    run(2 * 193);
    unframed = 0;                                                   // R8 mode change
    run(2 * 193);
    run(20);
    code_en = 0;                                                    // R3
    run(173 + 193 + 2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule